// File: doc/BRIEF.md
# Bus Slave Read-Data Source Selector

This block is the read-data output stage of a slave on a pipelined address/data bus. During an accepted address phase it records the word address of the transfer and whether the transfer is a read or a write. In the following data phase it uses that recorded address, and not whatever is on the address bus at the time, to choose what appears on its read-data output. The choice is between three sources: one register of a small register bank, the output of an external synchronous memory, or a status word supplied from outside.

Whenever the slave is not completing a read data phase, its read-data output is held at zero. This lets an interconnect combine the outputs of many slaves with a plain OR. Write transfers aimed at the register words update the bank with the write data presented in their data phase. Memory reads are launched from the live address phase, so the memory's one-cycle latency lines up with the data phase. The slave never inserts wait states.

Top module: `rdsel_slave`

## Requirements
- R1: `readyout_o` is 1 in every cycle, including during reset.
- R2: A transfer is accepted in a cycle only when `sel_i`=1, `ready_i`=1 and `trans_i` is 2'b10 (first) or 2'b11 (follow-on); 2'b00 (idle) and 2'b01 (busy) are never accepted. An accepted transfer with `write_i`=0 is a read, and its data phase is the next cycle.
- R3: Read data in a data phase depends only on the address captured at acceptance; changes on `addr_i`, `sel_i` or `trans_i` during the data phase do not change `rdata_o`.
- R4: Word addresses 0 to 7 (word address = `addr_i[7:2]`, `addr_i[1:0]` ignored) read the bank register with that index; every register is 0 after reset.
- R5: An accepted write to word 0 to 7 stores the `wdata_i` present in its data phase, at the end of that data phase; a read accepted in that same data-phase cycle returns the new value.
- R6: Word address 8 reads `status_i` as it stands during the data phase.
- R7: Word addresses 32 to 63 (`addr_i[7]`=1) read `mem_rdata_i` during the data phase.
- R8: `mem_en_o` is 1 in exactly the cycles where a read to word 32 to 63 is accepted, and then `mem_addr_o` equals `addr_i[6:2]`.
- R9: Reads of word addresses 9 to 31 return 0.
- R10: `rdata_o` is 0 in every cycle that is not the data phase of an accepted read (no transfer, deselected, idle, busy, or write).
- R11: While `ready_i`=0 nothing is accepted and the data phase in progress is held, so `rdata_o` keeps returning that read's source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select for the address phase |
| addr_i | input | 8 | Byte address for the address phase |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 first, 11 follow-on |
| write_i | input | 1 | 1 = write transfer |
| ready_i | input | 1 | Bus-wide ready; a phase completes when high |
| wdata_i | input | 32 | Write data, valid in the write's data phase |
| status_i | input | 32 | Status word returned for word address 8 |
| mem_rdata_i | input | 32 | Synchronous memory read output (one-cycle latency) |
| rdata_o | output | 32 | Read data, zero outside a read data phase |
| readyout_o | output | 1 | Slave ready, always 1 |
| mem_en_o | output | 1 | Memory read enable, address phase |
| mem_addr_o | output | 5 | Memory word offset, address phase |

## Verification
A captured address that is wrong or stale shows up as data from the wrong source in the very cycle after the transfer is accepted, so every read is checked in its own data phase, including back-to-back reads that switch between register, memory and status. The classic mistake of selecting by the live address is exposed by changing the address bus during a data phase and requiring the output to hold. A read-valid flag that stays set too long appears as nonzero data one cycle after a deselected, idle, busy or write transfer, and a flag that is lost during a stall shows as zero while the bus ready is low.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_STAT = 2'd2,
    SRC_MEM  = 2'd3
  } src_e;

  localparam logic [1:0] TR_IDLE  = 2'b00;
  localparam logic [1:0] TR_BUSY  = 2'b01;
  localparam logic [1:0] TR_FIRST = 2'b10;
  localparam logic [1:0] TR_NEXT  = 2'b11;

  // A transfer type that carries data (first or follow-on beat).
  function automatic logic carries_data(input logic [1:0] tr);
    return (tr == TR_FIRST) || (tr == TR_NEXT);
  endfunction

endpackage

// File: rtl/rdsel_decode.sv
module rdsel_decode
  import rdsel_pkg::*;
#(
  parameter int WORD_W    = 6,
  parameter int NREG      = 8,
  parameter int STAT_WORD = 8,
  localparam int IDX_W    = $clog2(NREG),
  localparam int MEM_AW   = WORD_W - 1
) (
  input  logic [WORD_W-1:0] word_i,
  output src_e              src_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic [MEM_AW-1:0] moff_o
);

  // Upper half of the word range is memory, then registers, then status.
  function automatic src_e classify(input logic [WORD_W-1:0] w);
    if (w[WORD_W-1])                       return SRC_MEM;
    else if (w < WORD_W'(NREG))            return SRC_REG;
    else if (w == WORD_W'(STAT_WORD))      return SRC_STAT;
    else                                   return SRC_NONE;
  endfunction

  assign src_o  = classify(word_i);
  assign ridx_o = word_i[IDX_W-1:0];
  assign moff_o = word_i[MEM_AW-1:0];

endmodule

// File: rtl/rdsel_capture.sv
module rdsel_capture #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dp_rd_o,
  output logic              dp_wr_o,
  output logic [WORD_W-1:0] dp_word_o
);

  // Address-phase state becomes data-phase state; held while ready is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_rd_o   <= 1'b0;
      dp_wr_o   <= 1'b0;
      dp_word_o <= '0;
    end else if (ready_i) begin
      dp_rd_o <= acc_rd_i;
      dp_wr_o <= acc_wr_i;
      if (acc_rd_i || acc_wr_i) dp_word_o <= word_i;
    end
  end

endmodule

// File: rtl/rdsel_regbank.sv
module rdsel_regbank #(
  parameter int NREG    = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] bank_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bank_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))    bank_q[g] <= wdata_i;
    end
  end

  assign rdata_o = bank_q[ridx_i];

endmodule

// File: rtl/rdsel_mux.sv
module rdsel_mux
  import rdsel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              dp_rd_i,
  input  src_e              src_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (dp_rd_i) begin
      case (src_i)
        SRC_REG:  rdata_o = reg_data_i;
        SRC_STAT: rdata_o = status_i;
        SRC_MEM:  rdata_o = mem_data_i;
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/rdsel_slave.sv
module rdsel_slave
  import rdsel_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NREG      = 8,
  parameter int STAT_WORD = 8,
  localparam int WORD_W   = ADDR_W - 2,
  localparam int MEM_AW   = WORD_W - 1,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic              mem_en_o,
  output logic [MEM_AW-1:0] mem_addr_o
);

  // Named internal events
  logic              acc_xfer;
  logic              acc_rd;
  logic              acc_wr;
  logic [WORD_W-1:0] live_word;
  src_e              live_src;
  logic [IDX_W-1:0]  live_ridx_unused;
  logic [MEM_AW-1:0] live_moff;
  logic              dp_rd;
  logic              dp_wr;
  logic [WORD_W-1:0] dp_word;
  src_e              dp_src;
  logic [IDX_W-1:0]  dp_ridx;
  logic [MEM_AW-1:0] dp_moff_unused;
  logic              reg_we;
  logic [DATA_W-1:0] reg_rdata;
  logic              addr_lsb_unused;

  assign live_word       = addr_i[ADDR_W-1:2];
  assign addr_lsb_unused = ^addr_i[1:0];

  assign acc_xfer = sel_i && ready_i && carries_data(trans_i);
  assign acc_rd   = acc_xfer && !write_i;
  assign acc_wr   = acc_xfer && write_i;

  rdsel_decode #(.WORD_W(WORD_W), .NREG(NREG), .STAT_WORD(STAT_WORD)) u_dec_live (
    .word_i (live_word),
    .src_o  (live_src),
    .ridx_o (live_ridx_unused),
    .moff_o (live_moff)
  );

  rdsel_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (ready_i),
    .acc_rd_i  (acc_rd),
    .acc_wr_i  (acc_wr),
    .word_i    (live_word),
    .dp_rd_o   (dp_rd),
    .dp_wr_o   (dp_wr),
    .dp_word_o (dp_word)
  );

  rdsel_decode #(.WORD_W(WORD_W), .NREG(NREG), .STAT_WORD(STAT_WORD)) u_dec_dp (
    .word_i (dp_word),
    .src_o  (dp_src),
    .ridx_o (dp_ridx),
    .moff_o (dp_moff_unused)
  );

  // Writes commit when their data phase completes.
  assign reg_we = dp_wr && ready_i && (dp_src == SRC_REG);

  rdsel_regbank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .widx_i  (dp_ridx),
    .wdata_i (wdata_i),
    .ridx_i  (dp_ridx),
    .rdata_o (reg_rdata)
  );

  rdsel_mux #(.DATA_W(DATA_W)) u_mux (
    .dp_rd_i    (dp_rd),
    .src_i      (dp_src),
    .reg_data_i (reg_rdata),
    .status_i   (status_i),
    .mem_data_i (mem_rdata_i),
    .rdata_o    (rdata_o)
  );

  // Memory read launched in the address phase so data lands in the data phase.
  assign mem_en_o   = acc_rd && (live_src == SRC_MEM);
  assign mem_addr_o = live_moff;
  assign readyout_o = 1'b1;

endmodule

// File: rtl/rdsel_chk.sv
module rdsel_chk #(
  parameter int WORD_W    = 6,
  parameter int DATA_W    = 32,
  parameter int NREG      = 8,
  parameter int STAT_WORD = 8,
  localparam int MEM_AW   = WORD_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic [WORD_W-1:0] word_i,
  input logic [1:0]        trans_i,
  input logic              write_i,
  input logic              ready_i,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              readyout_o,
  input logic              mem_en_o,
  input logic [MEM_AW-1:0] mem_addr_o
);

  logic              take_rd;
  logic              ph_rd;
  logic [WORD_W-1:0] ph_word;

  assign take_rd = sel_i && ready_i && trans_i[1] && !write_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_rd   <= 1'b0;
      ph_word <= '0;
    end else if (ready_i) begin
      ph_rd <= take_rd;
      if (take_rd) ph_word <= word_i;
    end
  end

  always_comb begin
    AST_READY_HIGH: assert (readyout_o === 1'b1); // R1
  end

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_rd |-> rdata_o == '0); // R10

  AST_MEM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o == (take_rd && word_i[WORD_W-1])); // R8

  AST_MEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o |-> mem_addr_o == word_i[MEM_AW-1:0]); // R8

  AST_MEM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_rd && ph_word[WORD_W-1]) |-> rdata_o == mem_rdata_i); // R7

  AST_STATUS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_rd && ph_word == WORD_W'(STAT_WORD)) |-> rdata_o == status_i); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_rd && !ph_word[WORD_W-1] && ph_word >= WORD_W'(NREG) &&
     ph_word != WORD_W'(STAT_WORD)) |-> rdata_o == '0); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_rd && !ready_i && ph_word[WORD_W-1]) |=> ph_rd && rdata_o == mem_rdata_i); // R11

endmodule

bind rdsel_slave rdsel_chk #(
  .WORD_W(ADDR_W - 2), .DATA_W(DATA_W), .NREG(NREG), .STAT_WORD(STAT_WORD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_i       (sel_i),
  .word_i      (addr_i[ADDR_W-1:2]),
  .trans_i     (trans_i),
  .write_i     (write_i),
  .ready_i     (ready_i),
  .status_i    (status_i),
  .mem_rdata_i (mem_rdata_i),
  .rdata_o     (rdata_o),
  .readyout_o  (readyout_o),
  .mem_en_o    (mem_en_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/rdsel_slave_tb.sv
module rdsel_slave_tb;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  trans_i = 2'b00;
  logic        write_i = 1'b0;
  logic        ready_i = 1'b1;
  logic [31:0] wdata_i = '0;
  logic [31:0] status_i = 32'h5A5A_0F0F;
  logic [31:0] mem_q = '0;
  logic [31:0] rdata_o;
  logic        readyout_o;
  logic        mem_en_o;
  logic [4:0]  mem_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  rdsel_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .trans_i(trans_i),
    .write_i(write_i), .ready_i(ready_i), .wdata_i(wdata_i), .status_i(status_i),
    .mem_rdata_i(mem_q), .rdata_o(rdata_o), .readyout_o(readyout_o),
    .mem_en_o(mem_en_o), .mem_addr_o(mem_addr_o)
  );

  function automatic logic [31:0] mem_word(input logic [4:0] off);
    return 32'hC0DE_0000 + 32'(off) * 32'h0000_0111;
  endfunction

  function automatic logic [31:0] reg_val(input int i);
    return 32'h1357_0000 ^ (32'(i) << 8) ^ 32'(i * 7 + 1);
  endfunction

  // One-cycle-latency synchronous memory model
  always_ff @(posedge clk) if (mem_en_o) mem_q <= mem_word(mem_addr_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one address phase at a falling edge, returns at the next falling
  // edge, which lies inside that transfer's data phase. wd is the write data
  // for the data phase that is current while this address is driven.
  task automatic step(input logic s, input logic [1:0] tr, input logic wr,
                      input logic [7:0] a, input logic [31:0] wd);
    sel_i = s; trans_i = tr; write_i = wr; addr_i = a; wdata_i = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ready in reset", {31'd0, readyout_o}, 32'd1);
    check("R10 rdata in reset", rdata_o, 32'd0);
    step(1, 2'b10, 0, 8'h0C, 0);
    check("R4 reg3 reset value", rdata_o, 32'd0);
    check("R1 ready after reset", {31'd0, readyout_o}, 32'd1);
  endtask

  task automatic t_reg_rw;
    logic [31:0] prev = '0;
    for (int i = 0; i < 8; i++) begin
      step(1, (i == 0) ? 2'b10 : 2'b11, 1, 8'(i * 4), prev);
      check("R10 write data phase zero", rdata_o, 32'd0);
      prev = reg_val(i);
    end
    step(0, 2'b00, 0, 8'h00, prev);
    for (int i = 0; i < 8; i++) begin
      step(1, 2'b10, 0, 8'(i * 4 + (i % 4)), 0);
      check("R4 reg read", rdata_o, reg_val(i));
    end
    // write then immediate read of the same register
    step(1, 2'b10, 1, 8'h14, 0);
    step(1, 2'b10, 0, 8'h14, 32'hDEAD_BEEF);
    check("R5 write then read", rdata_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_status;
    status_i = 32'h5A5A_0F0F;
    step(1, 2'b10, 0, 8'h20, 0);
    check("R6 status read", rdata_o, 32'h5A5A_0F0F);
    status_i = 32'h0123_4567;
    #1;
    check("R6 status follows input", rdata_o, 32'h0123_4567);
  endtask

  task automatic t_mem;
    sel_i = 1; trans_i = 2'b10; write_i = 0; addr_i = 8'h80;
    #1;
    check("R8 mem enable", {31'd0, mem_en_o}, 32'd1);
    check("R8 mem offset 0", {27'd0, mem_addr_o}, 32'd0);
    step(1, 2'b10, 0, 8'h80, 0);
    check("R7 mem offset 0 data", rdata_o, mem_word(5'd0));
    sel_i = 1; trans_i = 2'b11; write_i = 0; addr_i = 8'hFF;
    #1;
    check("R8 mem offset 31", {27'd0, mem_addr_o}, 32'd31);
    step(1, 2'b11, 0, 8'hFF, 0);
    check("R7 mem offset 31 data", rdata_o, mem_word(5'd31));
    sel_i = 1; trans_i = 2'b10; write_i = 1; addr_i = 8'h90;
    #1;
    check("R8 no mem enable for write", {31'd0, mem_en_o}, 32'd0);
    step(1, 2'b10, 1, 8'h90, 0);
    check("R10 mem write phase zero", rdata_o, 32'd0);
  endtask

  task automatic t_unmapped;
    step(1, 2'b10, 0, 8'h24, 0);
    check("R9 word 9", rdata_o, 32'd0);
    step(1, 2'b10, 0, 8'h7C, 0);
    check("R9 word 31", rdata_o, 32'd0);
  endtask

  task automatic t_qualify;
    status_i = 32'hAAAA_5555;
    step(0, 2'b10, 0, 8'h20, 0);
    check("R2 deselected", rdata_o, 32'd0);
    step(1, 2'b00, 0, 8'h20, 0);
    check("R2 idle", rdata_o, 32'd0);
    step(1, 2'b01, 0, 8'h20, 0);
    check("R2 busy", rdata_o, 32'd0);
    step(1, 2'b10, 1, 8'h20, 0);
    check("R10 write to status", rdata_o, 32'd0);
    step(1, 2'b11, 0, 8'h20, 0);
    check("R2 follow-on read", rdata_o, 32'hAAAA_5555);
  endtask

  task automatic t_switch;
    step(1, 2'b10, 0, 8'h08, 0);
    check("R3 reg2 in burst", rdata_o, reg_val(2));
    sel_i = 1; trans_i = 2'b10; write_i = 0; addr_i = 8'h20;
    #1;
    check("R3 live address ignored", rdata_o, reg_val(2));
    step(1, 2'b10, 0, 8'h94, 0);
    check("R3 mem after reg", rdata_o, mem_word(5'd5));
    step(1, 2'b10, 0, 8'h20, 0);
    check("R3 status after mem", rdata_o, 32'hAAAA_5555);
    step(1, 2'b10, 0, 8'h18, 0);
    check("R3 reg6 after status", rdata_o, reg_val(6));
    step(0, 2'b00, 0, 8'h00, 0);
    check("R10 idle after burst", rdata_o, 32'd0);
  endtask

  task automatic t_stall;
    step(1, 2'b10, 0, 8'h84, 0);
    check("R7 mem before stall", rdata_o, mem_word(5'd1));
    ready_i = 0;
    sel_i = 1; trans_i = 2'b10; write_i = 0; addr_i = 8'hA0;
    #1;
    check("R11 no mem launch in stall", {31'd0, mem_en_o}, 32'd0);
    step(1, 2'b10, 0, 8'h04, 0);
    check("R11 data held in stall", rdata_o, mem_word(5'd1));
    ready_i = 1;
    step(0, 2'b00, 0, 8'h00, 0);
    check("R11 stalled address not taken", rdata_o, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      check("R10 rdata held in reset", rdata_o, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_rw();
    t_status();
    t_mem();
    t_unmapped();
    t_qualify();
    t_switch();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule